// File: doc/BRIEF.md
# Severity-Grouped Error Aggregator

This block gathers up to 128 error inputs and sorts them into three groups of rising severity. Each channel has a sticky status bit. The block decides for each group whether a pending error raises an interrupt, drives the active-low device error pin, or does both. Group 1 (lowest severity) has a maskable interrupt, and a per-channel enable chooses whether it drives the pin. Group 2 raises an interrupt that cannot be masked and always drives the pin. Group 3 (highest severity) raises no interrupt and always drives the pin.

After the pin goes low, it stays low for a programmable minimum time, counted in ticks of a programmable prescaler. A three-state sequencer controls the pin:
- **PIN_IDLE**: the pin is high. The sequencer moves to PIN_HOLD when any pin-enabled status bit is set, and loads the low-time counter from the preload register on that transition.
- **PIN_HOLD**: the pin is low and the counter decrements on each prescaler tick. The sequencer moves to PIN_WAIT when the counter reaches zero.
- **PIN_WAIT**: the pin is still low. The sequencer returns to PIN_IDLE when software writes the release key and no pin-enabled status bit is set.

Separately, a test key in the control register holds the pin low for as long as the key is present. The test key does not touch any status bit or the sequencer.

Top module: `sev_err_aggregator`

## Requirements
- R1: A status bit is set at any clock edge where its error input is high. It stays set until software writes 1 to its bit position. If the error input is high in the same cycle as that clearing write, the bit stays set. Status word addresses are: 0 for group 1 channels 0–31, 1 for group 1 channels 32–63, 2 for group 2 and 3 for group 3. Channel n sits in bit n mod 32.
- R2: `irq_g1` is high whenever at least one group 1 status bit is set and its interrupt enable is also set. The interrupt enable words are at address 4 (channels 0–31) and address 5 (channels 32–63).
- R3: `irq_g2` is high whenever any group 2 status bit is set. No enable or mask affects it.
- R4: A group 3 error never raises either interrupt, but it always drives the pin low.
- R5: The pin goes low two clock edges after an error input is sampled, if that error is enabled for the pin. Pin-enabled errors are: any group 2 or group 3 channel, and any group 1 channel whose pin enable is set. The group 1 pin enable words are at address 6 (channels 0–31) and address 7 (channels 32–63). A group 1 error whose pin enable is clear leaves the pin high.
- R6: When the pin asserts, the low-time counter (readable at address 11) loads from the preload register (address 10). It then decrements once per prescaler tick. A tick occurs every (divider+1) clocks, where the divider is at address 9. A release key written before the counter reaches zero has no effect.
- R7: After the counter reaches zero, writing 0x5 to bits [3:0] of address 12 releases the pin (drives it high). The release happens only if no pin-enabled status bit is set at that time; otherwise the write is ignored and the pin stays low.
- R8: While bits [3:0] of the control register (address 8) hold 0xA, the pin is low. When any other value is written there, the pin returns to the state the sequencer gives. This test mode changes no status bit.
- R9: After reset, the pin is high, both interrupts are low, and all status, enable, control, divider, preload and counter registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_g1 | input | G1_N | Group 1 error inputs |
| err_g2 | input | G2_N | Group 2 error inputs |
| err_g3 | input | G3_N | Group 3 error inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| irq_g1 | output | 1 | Maskable group 1 interrupt |
| irq_g2 | output | 1 | Unmaskable group 2 interrupt |
| err_pin_n | output | 1 | Active-low device error pin |

## Verification
The bench builds the block with the full channel counts of 64, 32 and 32. This brings the upper group 1 word, with its separate enable addresses, and bit 31 of groups 2 and 3 within reach. The prescaler and low-time counter are built 8 bits wide. With a divider of 3 and preloads of 5 and 0, the bench exercises full hold windows, the zero-length window, and release attempts both early and late, all within a few dozen cycles each.

// File: rtl/sea_pkg.sv
package sea_pkg;

    localparam int AW = 4;
    localparam int DW = 32;

    typedef enum logic [1:0] {
        PIN_IDLE = 2'd0,
        PIN_HOLD = 2'd1,
        PIN_WAIT = 2'd2
    } pin_state_t;

    localparam logic [AW-1:0] A_G1S_LO = 4'd0;
    localparam logic [AW-1:0] A_G1S_HI = 4'd1;
    localparam logic [AW-1:0] A_G2S    = 4'd2;
    localparam logic [AW-1:0] A_G3S    = 4'd3;
    localparam logic [AW-1:0] A_G1I_LO = 4'd4;
    localparam logic [AW-1:0] A_G1I_HI = 4'd5;
    localparam logic [AW-1:0] A_G1P_LO = 4'd6;
    localparam logic [AW-1:0] A_G1P_HI = 4'd7;
    localparam logic [AW-1:0] A_CTRL   = 4'd8;
    localparam logic [AW-1:0] A_DIV    = 4'd9;
    localparam logic [AW-1:0] A_PRE    = 4'd10;
    localparam logic [AW-1:0] A_LTC    = 4'd11;
    localparam logic [AW-1:0] A_REL    = 4'd12;

    localparam logic [3:0] FORCE_KEY   = 4'hA;
    localparam logic [3:0] RELEASE_KEY = 4'h5;

endpackage

// File: rtl/sea_regs.sv
module sea_regs
    import sea_pkg::*;
#(
    parameter int G1_N  = 64,
    parameter int G2_N  = 32,
    parameter int G3_N  = 32,
    parameter int PRE_W = 16,
    parameter int LT_W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [G1_N-1:0] err_g1,
    input  logic [G2_N-1:0] err_g2,
    input  logic [G3_N-1:0] err_g3,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic [LT_W-1:0] lt_count,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq_g1,
    output logic            irq_g2,
    output logic            pin_req,
    output logic            force_on,
    output logic            release_wr,
    output logic [PRE_W-1:0] presc_div,
    output logic [LT_W-1:0]  lt_preload
);

    logic [G1_N-1:0] g1_stat, g1_ien, g1_pen;
    logic [G1_N-1:0] g1_clr, g1_ien_nxt, g1_pen_nxt;
    logic [G2_N-1:0] g2_stat, g2_clr;
    logic [G3_N-1:0] g3_stat, g3_clr;
    logic [3:0]      ctrl_key;
    logic [63:0]     g1s_pad, g1i_pad, g1p_pad;

    // per-channel decode of the group 1 word that holds each bit
    for (genvar i = 0; i < G1_N; i++) begin : g_g1_dec
        localparam logic [AW-1:0] SA = A_G1S_LO + 4'(i / 32);
        localparam logic [AW-1:0] IA = A_G1I_LO + 4'(i / 32);
        localparam logic [AW-1:0] PA = A_G1P_LO + 4'(i / 32);
        localparam int            B  = i % 32;
        assign g1_clr[i]     = reg_wr && (reg_addr == SA) && reg_wdata[B];
        assign g1_ien_nxt[i] = (reg_wr && reg_addr == IA) ? reg_wdata[B] : g1_ien[i];
        assign g1_pen_nxt[i] = (reg_wr && reg_addr == PA) ? reg_wdata[B] : g1_pen[i];
    end

    assign g2_clr = (reg_wr && reg_addr == A_G2S) ? reg_wdata[G2_N-1:0] : '0;
    assign g3_clr = (reg_wr && reg_addr == A_G3S) ? reg_wdata[G3_N-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g1_stat    <= '0;
            g1_ien     <= '0;
            g1_pen     <= '0;
            g2_stat    <= '0;
            g3_stat    <= '0;
            ctrl_key   <= '0;
            presc_div  <= '0;
            lt_preload <= '0;
        end else begin
            g1_stat <= err_g1 | (g1_stat & ~g1_clr);
            g2_stat <= err_g2 | (g2_stat & ~g2_clr);
            g3_stat <= err_g3 | (g3_stat & ~g3_clr);
            g1_ien  <= g1_ien_nxt;
            g1_pen  <= g1_pen_nxt;
            if (reg_wr && reg_addr == A_CTRL) ctrl_key   <= reg_wdata[3:0];
            if (reg_wr && reg_addr == A_DIV)  presc_div  <= reg_wdata[PRE_W-1:0];
            if (reg_wr && reg_addr == A_PRE)  lt_preload <= reg_wdata[LT_W-1:0];
        end
    end

    always_comb begin
        irq_g1     = |(g1_stat & g1_ien);
        irq_g2     = |g2_stat;
        pin_req    = (|(g1_stat & g1_pen)) | (|g2_stat) | (|g3_stat);
        force_on   = (ctrl_key == FORCE_KEY);
        release_wr = reg_wr && (reg_addr == A_REL) && (reg_wdata[3:0] == RELEASE_KEY);
    end

    always_comb begin
        g1s_pad = '0;
        g1i_pad = '0;
        g1p_pad = '0;
        g1s_pad[G1_N-1:0] = g1_stat;
        g1i_pad[G1_N-1:0] = g1_ien;
        g1p_pad[G1_N-1:0] = g1_pen;
        case (reg_addr)
            A_G1S_LO: reg_rdata = g1s_pad[31:0];
            A_G1S_HI: reg_rdata = g1s_pad[63:32];
            A_G2S:    reg_rdata = DW'(g2_stat);
            A_G3S:    reg_rdata = DW'(g3_stat);
            A_G1I_LO: reg_rdata = g1i_pad[31:0];
            A_G1I_HI: reg_rdata = g1i_pad[63:32];
            A_G1P_LO: reg_rdata = g1p_pad[31:0];
            A_G1P_HI: reg_rdata = g1p_pad[63:32];
            A_CTRL:   reg_rdata = DW'(ctrl_key);
            A_DIV:    reg_rdata = DW'(presc_div);
            A_PRE:    reg_rdata = DW'(lt_preload);
            A_LTC:    reg_rdata = DW'(lt_count);
            default:  reg_rdata = '0;
        endcase
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_G3S) |=> ((g3_stat & $past(g3_stat)) == $past(g3_stat))); // R1
    AST_CAPTURE_G2: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_g2) |=> (|g2_stat)); // R1
    AST_IRQ1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(err_g1 & g1_ien)) && !(reg_wr && (reg_addr == A_G1I_LO || reg_addr == A_G1I_HI)))
        |=> irq_g1); // R2
    AST_IRQ2_NOMASK: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_g2) |=> irq_g2); // R3

endmodule

// File: rtl/sea_prescaler.sv
module sea_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] presc_div,
    output logic             tick
);

    logic [PRE_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else if (tick) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    always_comb tick = (cnt == presc_div);

endmodule

// File: rtl/sea_pin_fsm.sv
module sea_pin_fsm
    import sea_pkg::*;
#(
    parameter int LT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            pin_req,
    input  logic            release_wr,
    input  logic            force_on,
    input  logic [LT_W-1:0] lt_preload,
    output logic [LT_W-1:0] lt_count,
    output logic            err_pin_n
);

    pin_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            PIN_IDLE: if (pin_req) state_nxt = PIN_HOLD;
            PIN_HOLD: if (lt_count == '0) state_nxt = PIN_WAIT;
            PIN_WAIT: if (release_wr && !pin_req) state_nxt = PIN_IDLE;
            default:  state_nxt = PIN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PIN_IDLE;
        else state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lt_count <= '0;
        else if (state == PIN_IDLE && pin_req) lt_count <= lt_preload;
        else if (state == PIN_HOLD && tick && lt_count != '0) lt_count <= lt_count - 1'b1;
    end

    always_comb begin
        err_pin_n = !((state != PIN_IDLE) || force_on);
    end

    AST_ERR_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PIN_IDLE && pin_req) |=> (state == PIN_HOLD)); // R5
    AST_HOLD_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PIN_HOLD) |=> (state != PIN_IDLE)); // R6
    AST_LTC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PIN_HOLD && tick && lt_count != '0) |=> (lt_count == $past(lt_count) - 1'b1)); // R6
    AST_WAIT_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PIN_WAIT && pin_req) |=> (state == PIN_WAIT)); // R7

endmodule

// File: rtl/sev_err_aggregator.sv
module sev_err_aggregator
    import sea_pkg::*;
#(
    parameter int G1_N  = 64,
    parameter int G2_N  = 32,
    parameter int G3_N  = 32,
    parameter int PRE_W = 16,
    parameter int LT_W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [G1_N-1:0] err_g1,
    input  logic [G2_N-1:0] err_g2,
    input  logic [G3_N-1:0] err_g3,
    input  logic            reg_wr,
    input  logic [3:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            irq_g1,
    output logic            irq_g2,
    output logic            err_pin_n
);

    logic             pin_req, force_on, release_wr, tick;
    logic [PRE_W-1:0] presc_div;
    logic [LT_W-1:0]  lt_preload, lt_count;

    sea_regs #(
        .G1_N(G1_N), .G2_N(G2_N), .G3_N(G3_N), .PRE_W(PRE_W), .LT_W(LT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .err_g1(err_g1), .err_g2(err_g2), .err_g3(err_g3),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .lt_count(lt_count), .reg_rdata(reg_rdata),
        .irq_g1(irq_g1), .irq_g2(irq_g2), .pin_req(pin_req),
        .force_on(force_on), .release_wr(release_wr),
        .presc_div(presc_div), .lt_preload(lt_preload)
    );

    sea_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .presc_div(presc_div), .tick(tick)
    );

    sea_pin_fsm #(.LT_W(LT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin_req(pin_req),
        .release_wr(release_wr), .force_on(force_on),
        .lt_preload(lt_preload), .lt_count(lt_count), .err_pin_n(err_pin_n)
    );

    AST_G3_DRIVES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_g3) |=> ##1 !err_pin_n); // R4
    AST_FORCE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[3:0] == FORCE_KEY) |=> !err_pin_n); // R8

endmodule

// File: tb/tb_sev_err_aggregator.sv
`timescale 1ns/1ps
module tb_sev_err_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] err_g1 = '0;
    logic [31:0] err_g2 = '0;
    logic [31:0] err_g3 = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_g1, irq_g2, err_pin_n;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    sev_err_aggregator #(.G1_N(64), .G2_N(32), .G3_N(32), .PRE_W(8), .LT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .err_g1(err_g1), .err_g2(err_g2), .err_g3(err_g3),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_g1(irq_g1), .irq_g2(irq_g2), .err_pin_n(err_pin_n)
    );

    // behavioural reference
    logic [63:0] m_g1, m_ien, m_pen, m_clr1;
    logic [31:0] m_g2, m_g3;
    logic [3:0]  m_ctrl;
    int m_div, m_pre, m_ltc, m_pc, m_st;
    bit m_tick, m_req, m_key;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_g1 = '0; m_ien = '0; m_pen = '0; m_g2 = '0; m_g3 = '0; m_ctrl = '0;
            m_div = 0; m_pre = 0; m_ltc = 0; m_pc = 0; m_st = 0;
        end else begin
            m_tick = (m_pc == m_div);
            m_req  = ((m_g1 & m_pen) != 0) || (m_g2 != 0) || (m_g3 != 0);
            m_key  = reg_wr && reg_addr == 4'd12 && reg_wdata[3:0] == 4'h5;
            if (m_st == 0) begin
                if (m_req) begin m_st = 1; m_ltc = m_pre; end
            end else if (m_st == 1) begin
                if (m_ltc == 0) m_st = 2;
                else if (m_tick) m_ltc = m_ltc - 1;
            end else if (m_key && !m_req) m_st = 0;
            m_pc = m_tick ? 0 : (m_pc + 1) % 256;
            m_clr1 = '0;
            if (reg_wr && reg_addr == 4'd0) m_clr1[31:0] = reg_wdata;
            if (reg_wr && reg_addr == 4'd1) m_clr1[63:32] = reg_wdata;
            m_g1 = err_g1 | (m_g1 & ~m_clr1);
            m_g2 = err_g2 | (m_g2 & ~((reg_wr && reg_addr == 4'd2) ? reg_wdata : 32'd0));
            m_g3 = err_g3 | (m_g3 & ~((reg_wr && reg_addr == 4'd3) ? reg_wdata : 32'd0));
            if (reg_wr) begin
                case (reg_addr)
                    4'd4:  m_ien[31:0]  = reg_wdata;
                    4'd5:  m_ien[63:32] = reg_wdata;
                    4'd6:  m_pen[31:0]  = reg_wdata;
                    4'd7:  m_pen[63:32] = reg_wdata;
                    4'd8:  m_ctrl = reg_wdata[3:0];
                    4'd9:  m_div = int'(reg_wdata[7:0]);
                    4'd10: m_pre = int'(reg_wdata[7:0]);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk(err_pin_n == !((m_st != 0) || (m_ctrl == 4'hA)), "R5/R6/R7/R8 pin vs model",
                err_pin_n, !((m_st != 0) || (m_ctrl == 4'hA)));
            chk(irq_g1 == ((m_g1 & m_ien) != 0), "R2 irq_g1 vs model", irq_g1, (m_g1 & m_ien) != 0);
            chk(irq_g2 == (m_g2 != 0), "R3 irq_g2 vs model", irq_g2, m_g2 != 0);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string what);
        @(negedge clk); reg_addr = a; #1;
        chk(reg_rdata == exp, what, reg_rdata, exp);
    endtask

    task automatic pulse(input logic [63:0] e1, input logic [31:0] e2, input logic [31:0] e3);
        @(negedge clk); err_g1 = e1; err_g2 = e2; err_g3 = e3;
        @(negedge clk); err_g1 = '0; err_g2 = '0; err_g3 = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle(1);
        // R9 reset state
        chk(err_pin_n == 1'b1, "R9 pin after reset", err_pin_n, 1);
        chk(irq_g1 == 1'b0 && irq_g2 == 1'b0, "R9 irqs after reset", {irq_g1, irq_g2}, 0);
        rd(4'd0, 0, "R9 g1 status lo");
        rd(4'd3, 0, "R9 g3 status");
        rd(4'd10, 0, "R9 preload");
        rd(4'd11, 0, "R9 counter");

        wr(4'd9, 3);
        wr(4'd10, 5);
        wr(4'd4, 32'h1);
        wr(4'd6, 32'h2);

        // R2 / R5: group 1 irq-only channel
        pulse(64'h1, 0, 0);
        settle(3);
        chk(irq_g1 == 1'b1, "R2 irq_g1 on enabled channel", irq_g1, 1);
        chk(err_pin_n == 1'b1, "R5 pin high for g1 without pin enable", err_pin_n, 1);
        rd(4'd0, 32'h1, "R1 sticky g1 bit0");
        pulse(64'h10, 0, 0);
        rd(4'd0, 32'h11, "R1 g1 bit4 captured");
        wr(4'd0, 32'h1);
        settle(1);
        chk(irq_g1 == 1'b0, "R2 irq_g1 drops after clear", irq_g1, 0);
        rd(4'd0, 32'h10, "R1 write-one-to-clear");

        // R5 / R6 / R7: pin-enabled group 1 channel
        pulse(64'h2, 0, 0);
        settle(2);
        chk(err_pin_n == 1'b0, "R5 pin low on g1 pin-enabled", err_pin_n, 0);
        wr(4'd12, 32'h5);
        settle(1);
        chk(err_pin_n == 1'b0, "R6 early release ignored", err_pin_n, 0);
        rd(4'd11, m_ltc, "R6 counter during hold");
        settle(40);
        rd(4'd11, 0, "R6 counter reached zero");
        wr(4'd12, 32'h5);
        settle(2);
        chk(err_pin_n == 1'b0, "R7 release refused while status set", err_pin_n, 0);
        wr(4'd0, 32'h12);
        wr(4'd12, 32'h5);
        settle(1);
        chk(err_pin_n == 1'b1, "R7 clean release", err_pin_n, 1);

        // R3: group 2 unmasked
        pulse(0, 32'h8000_0000, 0);
        settle(2);
        chk(irq_g2 == 1'b1, "R3 irq_g2 on bit31", irq_g2, 1);
        chk(err_pin_n == 1'b0, "R5 pin low on group 2", err_pin_n, 0);
        wr(4'd2, 32'h8000_0000);
        settle(30);
        wr(4'd12, 32'h5);
        settle(1);
        chk(err_pin_n == 1'b1, "R7 release after group 2", err_pin_n, 1);

        // R4: group 3 pin only
        pulse(0, 0, 32'h80);
        settle(2);
        chk(err_pin_n == 1'b0, "R4 pin low on group 3", err_pin_n, 0);
        chk(irq_g1 == 1'b0 && irq_g2 == 1'b0, "R4 no irq from group 3", {irq_g1, irq_g2}, 0);
        rd(4'd3, 32'h80, "R1 g3 captured");
        wr(4'd3, 32'h80);
        settle(30);
        wr(4'd12, 32'h5);
        settle(1);
        chk(err_pin_n == 1'b1, "R7 release after group 3", err_pin_n, 1);

        // R8: test force
        wr(4'd8, 32'h3);
        settle(1);
        chk(err_pin_n == 1'b1, "R8 wrong key has no effect", err_pin_n, 1);
        wr(4'd8, 32'hA);
        settle(1);
        chk(err_pin_n == 1'b0, "R8 force drives pin low", err_pin_n, 0);
        rd(4'd0, 0, "R8 force leaves g1 status");
        rd(4'd3, 0, "R8 force leaves g3 status");
        wr(4'd8, 32'h0);
        settle(1);
        chk(err_pin_n == 1'b1, "R8 pin released with key removed", err_pin_n, 1);

        // R1: set wins over same-cycle clear
        @(negedge clk); err_g2 = 32'h1; reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h1;
        @(negedge clk); err_g2 = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(4'd2, 32'h1, "R1 set beats clear");
        wr(4'd2, 32'h1);

        // R6: zero preload, high group 1 word
        wr(4'd10, 0);
        wr(4'd12, 32'h5);
        settle(30);
        wr(4'd12, 32'h5);
        settle(1);
        chk(err_pin_n == 1'b1, "R7 idle before high-word test", err_pin_n, 1);
        wr(4'd5, 32'h100);
        wr(4'd7, 32'h100);
        pulse(64'h100_0000_0000, 0, 0);
        settle(2);
        chk(irq_g1 == 1'b1, "R2 irq_g1 upper word", irq_g1, 1);
        chk(err_pin_n == 1'b0, "R5 pin low upper word", err_pin_n, 0);
        rd(4'd1, 32'h100, "R1 upper word status");
        wr(4'd1, 32'h100);
        wr(4'd12, 32'h5);
        settle(1);
        chk(err_pin_n == 1'b1, "R6 zero preload releases promptly", err_pin_n, 1);

        settle(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule